// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command engine behind one I2C master port. Software writes a 16-bit command word. Separate bits in that word ask for a start with an address, a transmit, a receive (with or without a closing NACK) and a stop. The engine then works through the requested phases in a fixed order against a byte-level bus interface: address first, then data out, then data in, then release. Bit timing on the wires is handled further down, by a byte-level bus agent that answers each request in the same cycle.

Transmit bytes come from one of two places. In byte mode they come from a single byte register. In pool mode they come from an indexed byte pool held outside the block. In both modes the first byte is also the address byte. The engine keeps a 4-bit bus state code and a bus-busy flag, and returns them in the read view of the command register. Five sticky event flags are cleared by writing 1 and feed the interrupt logic: ACK, NAK, receive-done, normal stop and abnormal stop.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the command read view is zero (state idle 0x0, not busy), all status flags are zero and no bus strobe is active.
- R2: A command write replaces command bits 15:0 only when `master_en` is 1 and no sequence is running. Any other write leaves the read view unchanged. Bits 2 and 7 to 15 are stored but have no effect. The read view is {state in bits 22:19, busy in bit 16, command in bits 15:0}. All other bits read 0.
- R3: If the start bit (bit 0) is set, `bus_start` pulses in the first cycle after the write is accepted. The address byte is `tx_byte`, or pool entry 0 when the pool bit (bit 6) is set. When the target accepts, status bit 0 (ACK) is set, the state becomes 0x8 and busy becomes 1.
- R4: A start issued while state bit 3 is set is a restart. If the target refuses the address, the state reads 0xA for a restart and 0x9 otherwise. Status bit 1 (NAK) is set and busy becomes 0. The transmit, receive and stop phases are then skipped, and their command bits stay set.
- R5: After an accepted start, the transmit bit (bit 1) is dropped in byte mode, and in pool mode when `pool_cnt_m1` is 0. Otherwise the pool bytes at indices 1 to `pool_cnt_m1` go out on consecutive cycles.
- R6: A transmit without a start sends `tx_byte` in byte mode, or pool entries 0 to `pool_cnt_m1` in pool mode. A NAK sets status bit 1, clears busy and ends the transmit. Success sets status bit 0. The transmit bit is then cleared and the state returns to 0x8.
- R7: When bit 3 or bit 4 is set and status bit 2 is clear, `bus_rx` pulses once. `bus_rx_nack` is high when bit 4 is set. `rx_byte` takes `bus_rdata`. Status bit 2 is set, bits 3 and 4 are cleared, and the state becomes 0x8. If status bit 2 is already set, the receive is skipped and both bits stay set.
- R8: A stop (bit 5) with state bit 3 set pulses `bus_stop`, clears busy and sets status bit 3. With state bit 3 clear, no stop is driven and status bit 4 is set. In both cases bit 5 is cleared and the state returns to 0x0.
- R9: A status flag is cleared by a `sts_clr_wr` pulse with that mask bit set. An event in the same cycle takes precedence over the clear.
- R10: Phases occupy consecutive cycles in this order: start, transmit (one cycle per byte), receive, stop. Each phase slot takes one cycle even when its bit is clear. At most one bus strobe is active per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| master_en | input | 1 | Master mode enable from the function control register |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word |
| cmd_rdata | output | 32 | Command/status read view |
| tx_byte | input | 8 | Byte-mode transmit/address byte |
| rx_byte | output | 8 | Last received byte |
| pool_cnt_m1 | input | IDXW (4) | Pool transmit count minus one |
| pool_idx | output | IDXW (4) | Pool read index |
| pool_data | input | 8 | Pool byte at `pool_idx` |
| bus_start | output | 1 | Start/restart with address request |
| bus_tx | output | 1 | Data byte transmit request |
| bus_wdata | output | 8 | Address or data byte for the bus agent |
| bus_nak | input | 1 | Agent reply to start or transmit: 1 means refused |
| bus_rx | output | 1 | Byte receive request |
| bus_rx_nack | output | 1 | Answer the received byte with NACK |
| bus_rdata | input | 8 | Byte returned by the agent on receive |
| bus_stop | output | 1 | Stop request, releases the bus |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Write-1-to-clear mask for the status flags |
| sts | output | 5 | Status flags: 0 ACK, 1 NAK, 2 receive-done, 3 normal stop, 4 abnormal stop |

## Verification
The assertions assume that the bus agent answers `bus_nak` in the same cycle as the strobe it refers to. They also assume that `pool_cnt_m1`, `pool_data` for the current index and `tx_byte` do not change while a sequence is running. The stimulus changes these inputs only between commands, and always waits for the longest possible sequence to finish. Apart from one directed case that writes while a sequence is still running, each command is written with the engine idle. Random words set every bit combination. Address bytes are mostly chosen to hit the target, and pool bytes sometimes carry the refusal value, so both the ACK and the NAK paths are exercised.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // bus state codes seen in bits 22:19 of the read view
  localparam logic [3:0] ST_IDLE    = 4'h0;
  localparam logic [3:0] ST_ACTIVE  = 4'h8;
  localparam logic [3:0] ST_START   = 4'h9;
  localparam logic [3:0] ST_RESTART = 4'hA;
  localparam logic [3:0] ST_TXD     = 4'hC;

  // command bit positions
  localparam int CB_START  = 0;
  localparam int CB_TX     = 1;
  localparam int CB_RX     = 3;
  localparam int CB_LAST   = 4;
  localparam int CB_STOP   = 5;
  localparam int CB_POOLTX = 6;
  localparam int CMD_W     = 16;

  // event / status flag positions
  localparam int EV_ACK   = 0;
  localparam int EV_NAK   = 1;
  localparam int EV_RXD   = 2;
  localparam int EV_STOP  = 3;
  localparam int EV_ABORT = 4;
  localparam int EV_W     = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_TX, PH_RX, PH_STOP
  } phase_e;
endpackage

// File: rtl/i2cs_status.sv
module i2cs_status
  import i2cs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] evt,
  input  logic            clr_wr,
  input  logic [EV_W-1:0] clr_mask,
  output logic [EV_W-1:0] sts
);
  logic [EV_W-1:0] sts_q, sts_d, clr_eff;
  logic            sts_en;

  always_comb begin
    clr_eff = clr_wr ? clr_mask : '0;
    sts_d   = (sts_q & ~clr_eff) | evt;
    sts_en  = clr_wr | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts = sts_q;

  // R9: an event always survives a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EV_RXD] |=> sts[EV_RXD]);
  // R6: ACK and NAK never reported in one cycle
  a_r6_ack_nak_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt[EV_ACK], evt[EV_NAK]}));
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic [7:0]       tx_byte,
  input  logic [IDXW-1:0]  pool_cnt_m1,
  input  logic [7:0]       pool_data,
  input  logic             bus_nak,
  input  logic [7:0]       bus_rdata,
  input  logic             rx_done,
  output logic [CMD_W-1:0] cmd_q,
  output logic [3:0]       state_q,
  output logic             busy_q,
  output logic [IDXW-1:0]  pool_idx,
  output logic             bus_start,
  output logic             bus_tx,
  output logic [7:0]       bus_wdata,
  output logic             bus_rx,
  output logic             bus_rx_nack,
  output logic             bus_stop,
  output logic [7:0]       rx_byte,
  output logic [EV_W-1:0]  evt
);
  phase_e           ph_q, ph_d;
  logic [CMD_W-1:0] cmd_d;
  logic [3:0]       st_d;
  logic             busy_d;
  logic [IDXW-1:0]  idx_q, idx_d;
  logic [7:0]       rxb_q, rxb_d;
  logic             pool_mode;

  assign pool_mode = cmd_q[CB_POOLTX];
  assign bus_wdata = pool_mode ? pool_data : tx_byte;
  assign pool_idx  = idx_q;
  assign rx_byte   = rxb_q;
  assign bus_rx_nack = bus_rx & cmd_q[CB_LAST];

  always_comb begin
    ph_d = ph_q; cmd_d = cmd_q; st_d = state_q; busy_d = busy_q;
    idx_d = idx_q; rxb_d = rxb_q; evt = '0;
    bus_start = 1'b0; bus_tx = 1'b0; bus_rx = 1'b0; bus_stop = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (cmd_wr && master_en) begin
          cmd_d = cmd_wdata;
          idx_d = '0;
          ph_d  = PH_START;
        end
      end
      PH_START: begin
        ph_d = PH_TX;
        if (cmd_q[CB_START]) begin
          bus_start       = 1'b1;
          cmd_d[CB_START] = 1'b0;
          if (bus_nak) begin
            evt[EV_NAK] = 1'b1;
            busy_d      = 1'b0;
            st_d        = state_q[3] ? ST_RESTART : ST_START;
            ph_d        = PH_IDLE;
          end else begin
            evt[EV_ACK] = 1'b1;
            busy_d      = 1'b1;
            st_d        = ST_ACTIVE;
            if (!pool_mode || pool_cnt_m1 == '0) cmd_d[CB_TX] = 1'b0;
            else                                  idx_d = IDXW'(1);
          end
        end
      end
      PH_TX: begin
        if (cmd_q[CB_TX]) begin
          bus_tx = 1'b1;
          if (bus_nak) begin
            evt[EV_NAK]  = 1'b1;
            busy_d       = 1'b0;
            cmd_d[CB_TX] = 1'b0;
            st_d         = ST_ACTIVE;
            ph_d         = PH_RX;
          end else if (pool_mode && idx_q != pool_cnt_m1) begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_TXD;
          end else begin
            evt[EV_ACK]  = 1'b1;
            cmd_d[CB_TX] = 1'b0;
            st_d         = ST_ACTIVE;
            ph_d         = PH_RX;
          end
        end else begin
          ph_d = PH_RX;
        end
      end
      PH_RX: begin
        ph_d = PH_STOP;
        if ((cmd_q[CB_RX] || cmd_q[CB_LAST]) && !rx_done) begin
          bus_rx         = 1'b1;
          rxb_d          = bus_rdata;
          evt[EV_RXD]    = 1'b1;
          cmd_d[CB_RX]   = 1'b0;
          cmd_d[CB_LAST] = 1'b0;
          st_d           = ST_ACTIVE;
        end
      end
      PH_STOP: begin
        ph_d = PH_IDLE;
        if (cmd_q[CB_STOP]) begin
          cmd_d[CB_STOP] = 1'b0;
          st_d           = ST_IDLE;
          if (state_q[3]) begin
            bus_stop     = 1'b1;
            busy_d       = 1'b0;
            evt[EV_STOP] = 1'b1;
          end else begin
            evt[EV_ABORT] = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cmd_q   <= '0;
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      rxb_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      cmd_q   <= cmd_d;
      state_q <= st_d;
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      rxb_q   <= rxb_d;
    end
  end

  // R2: a write with master mode off leaves the command unchanged
  a_r2_disabled_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && cmd_wr && !master_en) |=> (cmd_q == $past(cmd_q)));
  // R10: never two bus strobes in one cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_start, bus_tx, bus_rx, bus_stop}));
  // R8: a driven stop leaves the engine idle and the bus free
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state_q == ST_IDLE && !busy_q));
  // R7: no receive while receive-done is pending
  a_r7_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rx |-> !rx_done);
  // R4: refused address ends the sequence
  a_r4_nak_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && bus_nak) |=> (ph_q == PH_IDLE && !busy_q));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int POOL_DEPTH = 16,
  localparam int IDXW = $clog2(POOL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_wdata,
  output logic [31:0]      cmd_rdata,
  input  logic [7:0]       tx_byte,
  output logic [7:0]       rx_byte,
  input  logic [IDXW-1:0]  pool_cnt_m1,
  output logic [IDXW-1:0]  pool_idx,
  input  logic [7:0]       pool_data,
  output logic             bus_start,
  output logic             bus_tx,
  output logic [7:0]       bus_wdata,
  input  logic             bus_nak,
  output logic             bus_rx,
  output logic             bus_rx_nack,
  input  logic [7:0]       bus_rdata,
  output logic             bus_stop,
  input  logic             sts_clr_wr,
  input  logic [4:0]       sts_clr_mask,
  output logic [4:0]       sts
);
  logic [CMD_W-1:0] cmd_q;
  logic [3:0]       state_q;
  logic             busy_q;
  logic [EV_W-1:0]  evt;

  i2cs_seq #(.IDXW(IDXW)) u_seq (
    .clk, .rst_n, .master_en, .cmd_wr, .cmd_wdata, .tx_byte, .pool_cnt_m1,
    .pool_data, .bus_nak, .bus_rdata, .rx_done(sts[EV_RXD]),
    .cmd_q, .state_q, .busy_q, .pool_idx, .bus_start, .bus_tx, .bus_wdata,
    .bus_rx, .bus_rx_nack, .bus_stop, .rx_byte, .evt
  );

  i2cs_status u_sts (
    .clk, .rst_n, .evt, .clr_wr(sts_clr_wr), .clr_mask(sts_clr_mask), .sts
  );

  assign cmd_rdata = {9'b0, state_q, 2'b0, busy_q, cmd_q};

  // R7: a receive always raises receive-done
  a_r7_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rx |=> sts[EV_RXD]);
  // R8: stop is never driven from a non-active state
  a_r8_no_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |-> cmd_rdata[22]);
endmodule

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic master_en = 0, cmd_wr = 0;
  logic [15:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [7:0] tx_byte = '0, rx_byte, bus_wdata, bus_rdata = '0, pool_data;
  logic [IW-1:0] pool_cnt_m1 = '0, pool_idx;
  logic bus_start, bus_tx, bus_nak, bus_rx, bus_rx_nack, bus_stop;
  logic sts_clr_wr = 0;
  logic [4:0] sts_clr_mask = '0, sts;
  logic [7:0] pool_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq #(.POOL_DEPTH(DEPTH)) uut (
    .clk, .rst_n, .master_en, .cmd_wr, .cmd_wdata, .cmd_rdata, .tx_byte,
    .rx_byte, .pool_cnt_m1, .pool_idx, .pool_data, .bus_start, .bus_tx,
    .bus_wdata, .bus_nak, .bus_rx, .bus_rx_nack, .bus_rdata, .bus_stop,
    .sts_clr_wr, .sts_clr_mask, .sts
  );

  assign pool_data = pool_mem[pool_idx];
  // byte-level bus agent: target address 0x50, data byte 0xEE is refused
  always_comb bus_nak = bus_start ? (bus_wdata[7:1] != 7'h50)
                                  : (bus_tx && bus_wdata == 8'hEE);

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_state = 4'h0;
  logic m_busy = 0;
  logic [4:0] m_sts = '0;
  logic [7:0] m_rx = '0;
  logic [15:0] m_cmd = '0;
  int e_ns, e_ntx, e_nrx, e_nstp;
  logic e_nack;
  logic [7:0] e_tx [DEPTH];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_view();
    return {9'b0, m_state, 2'b0, m_busy, m_cmd};
  endfunction

  task automatic model_cmd(input logic [15:0] w);
    logic [15:0] c; logic [7:0] a, d; bit early, nakd; int first, last;
    c = w; early = 0; nakd = 0; first = 0;
    e_ns = 0; e_ntx = 0; e_nrx = 0; e_nstp = 0; e_nack = 0;
    if (c[0]) begin
      e_ns = 1; a = c[6] ? pool_mem[0] : tx_byte; c[0] = 0;
      if (a[7:1] != 7'h50) begin
        m_sts |= 5'd2; m_busy = 0; m_state = m_state[3] ? 4'hA : 4'h9; early = 1;
      end else begin
        m_sts |= 5'd1; m_busy = 1; m_state = 4'h8;
        if (!c[6] || pool_cnt_m1 == 0) c[1] = 0; else first = 1;
      end
    end
    if (!early && c[1]) begin
      last = c[6] ? int'(pool_cnt_m1) : 0;
      for (int i = first; i <= last; i++) begin
        d = c[6] ? pool_mem[i] : tx_byte;
        e_tx[e_ntx] = d; e_ntx++;
        if (d == 8'hEE) begin nakd = 1; break; end
      end
      if (nakd) begin m_sts |= 5'd2; m_busy = 0; end else m_sts |= 5'd1;
      c[1] = 0; m_state = 4'h8;
    end
    if (!early && (c[3] || c[4]) && !m_sts[2]) begin
      e_nrx = 1; e_nack = c[4]; m_rx = bus_rdata; m_sts |= 5'd4;
      c[3] = 0; c[4] = 0; m_state = 4'h8;
    end
    if (!early && c[5]) begin
      if (m_state[3]) begin e_nstp = 1; m_busy = 0; m_sts |= 5'd8; end
      else m_sts |= 5'd16;
      c[5] = 0; m_state = 4'h0;
    end
    m_cmd = c;
  endtask

  // issue a command and watch the bus; dbl keeps a second write up one cycle,
  // clr_cyc pulses a full status clear in that cycle slot
  task automatic run_cmd(input logic [15:0] w, input bit dbl, input int clr_cyc);
    int ns = 0, ntx = 0, nrx = 0, nstp = 0;
    logic nack = 0;
    logic [7:0] cap [DEPTH];
    model_cmd(w);
    @(negedge clk); cmd_wr = 1; cmd_wdata = w;
    for (int c = 1; c <= 24; c++) begin
      @(negedge clk);
      cmd_wr = (c == 1) ? dbl : 1'b0;
      if (c == 1) cmd_wdata = 16'h0021;
      sts_clr_wr = (c == clr_cyc); sts_clr_mask = 5'h1F;
      if (bus_start) ns++;
      if (bus_tx) begin if (ntx < DEPTH) cap[ntx] = bus_wdata; ntx++; end
      if (bus_rx) begin nrx++; nack = bus_rx_nack; end
      if (bus_stop) nstp++;
    end
    sts_clr_wr = 0;
    check("R3 start strobes", ns, e_ns);
    check("R5 transmit byte count", ntx, e_ntx);
    for (int i = 0; i < e_ntx && i < ntx; i++) check("R6 transmit byte", cap[i], e_tx[i]);
    check("R7 receive strobes", nrx, e_nrx);
    if (e_nrx != 0) begin
      check("R7 nack flag", nack, e_nack);
      check("R7 received byte", rx_byte, m_rx);
    end
    check("R8 stop strobes", nstp, e_nstp);
  endtask

  task automatic check_state(input string tag);
    check(tag, cmd_rdata, exp_view());
    check(tag, sts, m_sts);
  endtask

  task automatic clear_sts(input logic [4:0] mask);
    @(negedge clk); sts_clr_wr = 1; sts_clr_mask = mask;
    @(negedge clk); sts_clr_wr = 0;
    m_sts &= ~mask;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int strobes;
    void'($urandom(32'h5EED1));
    for (int i = 0; i < DEPTH; i++) pool_mem[i] = 8'h10 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 read view", cmd_rdata, 32'h0);
    check("R1 status", sts, 5'h0);
    check("R1 strobes", {bus_start, bus_tx, bus_rx, bus_stop}, 4'h0);

    // R2 write with master mode off
    strobes = 0;
    cmd_wr = 1; cmd_wdata = 16'h0021;
    @(negedge clk); cmd_wr = 0;
    repeat (6) begin
      @(negedge clk);
      if (bus_start || bus_stop) strobes++;
    end
    check("R2 disabled write ignored", cmd_rdata, 32'h0);
    check("R2 disabled write no strobes", strobes, 0);
    master_en = 1;

    // R3 accepted start in byte mode
    tx_byte = 8'hA0;
    run_cmd(16'h0001, 0, 0); check_state("R3 start accepted");
    // R4 restart refused, later phases skipped
    tx_byte = 8'h22;
    run_cmd(16'h0023, 0, 0); check_state("R4 restart refused");
    // R8 normal stop from restart state
    run_cmd(16'h0020, 0, 0); check_state("R8 normal stop");
    // R8/R9 abnormal stop while a full clear arrives in the same cycle
    run_cmd(16'h0020, 0, 4);
    m_sts = 5'h10;
    check_state("R9 event beats clear");
    // R4 first start refused
    tx_byte = 8'h44;
    run_cmd(16'h0001, 0, 0); check_state("R4 start refused");
    run_cmd(16'h0020, 0, 0); check_state("R8 stop after refusal");
    clear_sts(5'h1F);
    // R5 pool transmit skipping address byte
    pool_mem[0] = 8'hA1; pool_mem[1] = 8'h31; pool_mem[2] = 8'h32; pool_mem[3] = 8'h33;
    pool_cnt_m1 = 3;
    run_cmd(16'h0043, 0, 0); check_state("R5 pool transmit");
    pool_cnt_m1 = 0;
    run_cmd(16'h0043, 0, 0); check_state("R5 single pool entry");
    tx_byte = 8'hA0;
    run_cmd(16'h0003, 0, 0); check_state("R5 byte mode drop");
    // R6 refused data byte, then stop
    pool_mem[2] = 8'hEE; pool_cnt_m1 = 3;
    run_cmd(16'h0063, 0, 0); check_state("R6 data refused");
    clear_sts(5'h1F);
    // R7 receive with last
    tx_byte = 8'hA1; bus_rdata = 8'h5A;
    run_cmd(16'h0019, 0, 0); check_state("R7 receive last");
    bus_rdata = 8'h77;
    run_cmd(16'h0008, 0, 0); check_state("R7 receive skipped");
    clear_sts(5'h04);
    // R10/R2 second write during a running sequence is ignored
    pool_mem[2] = 8'h32; pool_cnt_m1 = 5;
    run_cmd(16'h0063, 1, 0); check_state("R10 sequence with busy write");

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      tx_byte = ($urandom % 3 != 0) ? {7'h50, 1'($urandom)} : 8'($urandom);
      for (int i = 0; i < DEPTH; i++)
        pool_mem[i] = ($urandom % 8 == 0) ? 8'hEE : 8'($urandom);
      if ($urandom % 3 != 0) pool_mem[0] = {7'h50, 1'($urandom)};
      pool_cnt_m1 = IW'($urandom % 8);
      bus_rdata = 8'($urandom);
      if ($urandom % 3 == 0) clear_sts(5'($urandom));
      run_cmd(w, 0, 0);
      check_state("R10 random command");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule